// File: doc/BRIEF.md
# Masked Multi-Port GPIO Register Block

This block gives a processor word-level control over several general-purpose I/O ports through a small synchronous register bus. Each port has five registers. The first is a direction word that turns each pin into an output or an input. The second is a protection mask. The third is a pin word, used to write the output latch or read the live pin levels. The last two are a set word and a clear word, which change individual output bits without a read-modify-write.

The protection mask decides which pins a piece of software may touch. A mask bit of 1 freezes the output latch bit against pin, set and clear writes. It also hides that pin in pin reads, where the bit reads as 0. Pin levels pass through a two-flop synchronizer before they can be read. The output enable of each pin follows its direction bit, and the driven level is its output latch bit.

The bus has no back-pressure. A write or a read is accepted in every cycle in which its enable is high. Read data is registered and appears on the cycle after the read enable. In any other cycle it is zero.

Top module: `mgpio_ctrl`

## Requirements
- R1: After reset every direction, mask and output latch bit is 0. `pin_out`, `pin_oe` and `bus_rdata` are all 0.
- R2: Address bits [ADDR_W-1:5] select the port, so port p starts at byte address p*0x20. Bits [4:0] select the register: 0x00 direction, 0x10 mask, 0x14 pin, 0x18 set, 0x1C clear. Any other value of [4:0] is unmapped, and so is any port index of NUM_PORTS or above.
- R3: The direction register can be read and written in full. Direction bit 1 makes the pin an output, and `pin_oe` of that pin equals its direction bit.
- R4: A write to the pin register loads the write data into the unmasked latch bits. Latch bits whose mask bit is 1 keep their value.
- R5: A write to the set register drives high each unmasked latch bit whose write data bit is 1. Write data bits of 0 leave their latch bits unchanged.
- R6: A write to the clear register drives low each unmasked latch bit whose write data bit is 1. Write data bits of 0 leave their latch bits unchanged. A read of the clear register returns 0.
- R7: A pin register read returns the synchronized pin input ANDed with the inverted mask, whatever the pin's direction. A level change on `pin_in` becomes visible in the read data of a read issued two cycles later.
- R8: A read of the set register returns the full output latch. The mask does not apply to this read.
- R9: The mask register can be read and written in full. Mask and direction writes are not gated by the mask.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.
- R11: `bus_rdata` carries the read result in the cycle after `bus_rd_en` and is 0 otherwise. A read and a write in the same cycle return the value from before the write.
- R12: `pin_out` and `pin_oe` change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, accepted every cycle |
| bus_wdata | input | PORT_W | Write data |
| bus_rd_en | input | 1 | Read strobe, accepted every cycle |
| bus_rdata | output | PORT_W | Registered read data, valid the cycle after `bus_rd_en` |
| pin_in | input | NUM_PORTS*PORT_W | Raw pin levels, port p at bits [p*PORT_W +: PORT_W] |
| pin_out | output | NUM_PORTS*PORT_W | Output latch levels |
| pin_oe | output | NUM_PORTS*PORT_W | Output enables (direction bits) |

## Verification
The bench writes pin, set and clear words under partial masks. A design that ignored the mask, or used the new mask in the same cycle as a mask write, would move frozen bits on `pin_out`. It sends zero-valued set and clear words, which a design that copied the data into the latch would act on. It reads pin words while `pin_in` changes and the mask hides some pins. A design with the wrong synchronizer depth or a missing AND would return stale or unmasked levels. It also probes near-miss offsets such as 0x04 and 0x15, port indices past the last port, and a read and a write to the same register in one cycle. These catch loose address decoding and reads that show the post-write value.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

  localparam int OFFSET_W = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_MASK,
    SEL_PIN,
    SEL_SET,
    SEL_CLR
  } reg_sel_e;

  // Register select from the low address bits; everything else is unmapped.
  function automatic reg_sel_e decode_offset(input logic [OFFSET_W-1:0] off);
    reg_sel_e s;
    case (off)
      5'h00:   s = SEL_DIR;
      5'h10:   s = SEL_MASK;
      5'h14:   s = SEL_PIN;
      5'h18:   s = SEL_SET;
      5'h1C:   s = SEL_CLR;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rd_word
);

  logic [W-1:0] open_bits;
  logic [W-1:0] out_next;

  // Only bits with a clear mask bit are open to pin, set and clear writes.
  assign open_bits = wdata & ~mask_q;

  always_comb begin
    case (sel)
      SEL_PIN: out_next = (out_q & mask_q) | open_bits;
      SEL_SET: out_next = out_q | open_bits;
      SEL_CLR: out_next = out_q & ~open_bits;
      default: out_next = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else if (wr_hit) begin
      if (sel == SEL_DIR)  dir_q  <= wdata;
      if (sel == SEL_MASK) mask_q <= wdata;
      out_q <= out_next;
    end
  end

  always_comb begin
    case (sel)
      SEL_DIR:  rd_word = dir_q;
      SEL_MASK: rd_word = mask_q;
      SEL_PIN:  rd_word = pin_sync & ~mask_q;
      SEL_SET:  rd_word = out_q;
      default:  rd_word = '0;
    endcase
  end

endmodule

// File: rtl/mgpio_ctrl.sv
module mgpio_ctrl
  import mgpio_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr_en,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic                        bus_rd_en,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);

  localparam int IDX_W   = ADDR_W - OFFSET_W;
  localparam int TOTAL_W = NUM_PORTS * PORT_W;

  reg_sel_e           sel;
  logic [IDX_W-1:0]   port_idx;
  logic [TOTAL_W-1:0] pin_sync;
  logic [TOTAL_W-1:0] mask_flat;
  logic [PORT_W-1:0]  rd_words [NUM_PORTS];
  logic [PORT_W-1:0]  rd_pick;

  assign sel      = decode_offset(bus_addr[OFFSET_W-1:0]);
  assign port_idx = bus_addr[ADDR_W-1:OFFSET_W];

  mgpio_sync #(.W(TOTAL_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_hit;
    assign wr_hit = bus_wr_en && (port_idx == IDX_W'(p));

    mgpio_port #(.W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit),
      .sel      (sel),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync[p*PORT_W +: PORT_W]),
      .dir_q    (pin_oe[p*PORT_W +: PORT_W]),
      .mask_q   (mask_flat[p*PORT_W +: PORT_W]),
      .out_q    (pin_out[p*PORT_W +: PORT_W]),
      .rd_word  (rd_words[p])
    );
  end

  // Port indices past the last port match nothing and read as zero.
  always_comb begin
    rd_pick = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_idx == IDX_W'(p)) rd_pick = rd_words[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_pick;
    else                bus_rdata <= '0;
  end

endmodule

// File: rtl/mgpio_ctrl_chk.sv
module mgpio_ctrl_chk #(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_wr_en,
  input logic                        bus_rd_en,
  input logic [PORT_W-1:0]           bus_rdata,
  input logic [NUM_PORTS*PORT_W-1:0] pin_out,
  input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input logic [NUM_PORTS*PORT_W-1:0] mask_flat
);

  // R12
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pin_out) && $stable(pin_oe));

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> bus_rdata == '0);

  // R4
  mask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |=> ((pin_out ^ $past(pin_out)) & $past(mask_flat)) == '0);

  // R5
  set_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[4:0] == 5'h18) |=> ($past(pin_out) & ~pin_out) == '0);

  // R6
  clr_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[4:0] == 5'h1C) |=> (pin_out & ~$past(pin_out)) == '0);

  // R6
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr[4:0] == 5'h1C) |=> bus_rdata == '0);

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[4:0] == 5'h04) |=> $stable(pin_out) && $stable(pin_oe));

endmodule

bind mgpio_ctrl mgpio_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mask_flat (mask_flat)
);

// File: tb/mgpio_ctrl_bench.sv
module mgpio_ctrl_bench;

  localparam int NP = 5;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int TW = NP * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic          bus_rd_en = 1'b0;
  logic [W-1:0]  bus_rdata;
  logic [TW-1:0] pin_in = '0;
  logic [TW-1:0] pin_out;
  logic [TW-1:0] pin_oe;

  always #5 clk = ~clk;

  mgpio_ctrl u_mgpio_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // Behavioural reference model
  logic [W-1:0]  m_dir  [NP];
  logic [W-1:0]  m_mask [NP];
  logic [W-1:0]  m_out  [NP];
  logic [TW-1:0] m_s1 = '0;
  logic [TW-1:0] m_s2 = '0;
  logic [W-1:0]  m_rd = '0;

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_dir[p] = '0; m_mask[p] = '0; m_out[p] = '0;
    end
  end

  function automatic logic [W-1:0] m_read(input int a);
    int idx = a / 32;
    int off = a % 32;
    if (idx >= NP) return '0;
    case (off)
      0:  return m_dir[idx];
      16: return m_mask[idx];
      20: return m_s2[idx*W +: W] & ~m_mask[idx];
      24: return m_out[idx];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_dir[p] = '0; m_mask[p] = '0; m_out[p] = '0;
      end
      m_s1 = '0; m_s2 = '0; m_rd = '0;
    end else begin
      logic [W-1:0] nrd;
      int idx;
      int off;
      logic [W-1:0] open_b;
      nrd = bus_rd_en ? m_read(int'(bus_addr)) : '0;
      idx = int'(bus_addr) / 32;
      off = int'(bus_addr) % 32;
      if (bus_wr_en && idx < NP) begin
        open_b = bus_wdata & ~m_mask[idx];
        case (off)
          0:  m_dir[idx]  = bus_wdata;
          16: m_mask[idx] = bus_wdata;
          20: m_out[idx]  = (m_out[idx] & m_mask[idx]) | open_b;
          24: m_out[idx]  = m_out[idx] | open_b;
          28: m_out[idx]  = m_out[idx] & ~open_b;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_rd = nrd;
    end
  end

  task automatic check(input string what, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      logic [TW-1:0] e_out;
      logic [TW-1:0] e_oe;
      for (int p = 0; p < NP; p++) begin
        e_out[p*W +: W] = m_out[p];
        e_oe[p*W +: W]  = m_dir[p];
      end
      check("pin_out", pin_out, e_out);
      check("pin_oe", pin_oe, e_oe);
      check("bus_rdata", TW'(bus_rdata), TW'(m_rd));
    end
  end

  task automatic wr(input int a, input logic [W-1:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    bus_addr = AW'(a); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic rdwr(input int a, input logic [W-1:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr_en = 1'b1; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(32'h00); rd(32'h10); rd(32'h18); idle(1);

    // R3: direction write and read back, oe follows
    cur_req = "R3";
    wr(32'h20, 32'hF0F0_0001); rd(32'h20); idle(1);

    // R4 / R8: unmasked pin write, read latch via set register
    cur_req = "R4";
    wr(32'h34, 32'hDEAD_BEEF);
    cur_req = "R8";
    rd(32'h38); idle(1);

    // R9: mask write, then masked pin write and mask read
    cur_req = "R9";
    wr(32'h30, 32'h0000_FFFF); rd(32'h30);
    wr(32'h20, 32'h1234_5678); rd(32'h20);
    cur_req = "R4";
    wr(32'h34, 32'h1234_5678); rd(32'h38); idle(1);

    // R5: set with ones and with zeros
    cur_req = "R5";
    wr(32'h38, 32'hFFFF_FFFF); wr(32'h38, 32'h0000_0000); rd(32'h38);

    // R6: clear with ones, with zeros, read of clear register
    cur_req = "R6";
    wr(32'h3C, 32'h0000_0000); wr(32'h3C, 32'hA5A5_A5A5); rd(32'h3C); rd(32'h38); idle(1);

    // R7: live pin reads through the synchronizer, masked and unmasked
    cur_req = "R7";
    pin_in = {5{32'hCAFE_F00D}};
    rd(32'h34); rd(32'h34); rd(32'h34); rd(32'h94);
    pin_in = {5{32'h1357_9BDF}};
    rd(32'h14); rd(32'h14); rd(32'h14); rd(32'h34); idle(1);

    // R2: other ports and last port are independent
    cur_req = "R2";
    wr(32'h80, 32'hFFFF_0000); wr(32'h98, 32'h0F0F_0F0F); rd(32'h98); rd(32'h00); idle(1);

    // R10: unmapped offsets and port indices
    cur_req = "R10";
    wr(32'h04, 32'hFFFF_FFFF); wr(32'h15, 32'hFFFF_FFFF); wr(32'hA0, 32'hFFFF_FFFF);
    wr(32'hF8, 32'hFFFF_FFFF); rd(32'h04); rd(32'hB4); rd(32'hE0); idle(1);

    // R11: read and write to the same register in one cycle
    cur_req = "R11";
    rdwr(32'h58, 32'h8000_0001); rd(32'h58); rdwr(32'h50, 32'h0000_00FF); rd(32'h50); idle(2);

    // R12: mixed traffic with randomly chosen accesses
    cur_req = "R12";
    for (int i = 0; i < 400; i++) begin
      int offs[6] = '{0, 16, 20, 24, 28, 4};
      int a = 32 * ($urandom % 6) + offs[$urandom % 6];
      int kind = $urandom % 4;
      if (i % 7 == 0) begin
        for (int p = 0; p < NP; p++) pin_in[p*W +: W] = $urandom;
      end
      case (kind)
        0: wr(a, $urandom);
        1: rd(a);
        2: rdwr(a, $urandom);
        default: idle(1);
      endcase
    end
    idle(3);

    finished = 1;
    summary();
    $finish;
  end

endmodule